// File: doc/BRIEF.md
# NAND Flash Host Command Sequencer

This block sits between a host request port and an 8-bit asynchronous NAND flash device. One request names an operation, a row address, a column address and a byte count. The sequencer turns it into the bus phases the device expects: a command cycle, the address cycles, data transfers strobed on the write or read strobe, a second command where the operation needs one, a wait for the device to report ready, and a status read where the operation needs one. Write data arrives on a byte stream with a valid/ready handshake. Read data leaves on a byte stream marked by a one-cycle valid. Each operation ends with a one-cycle `done` pulse that carries a fail flag, a timeout flag and the last status byte read.

A page program takes more than one request. `LOAD` opens the page buffer and streams data into it. `RANDIN` may follow any number of times to move the column and add more data. `EXEC` then commits the buffer. Strobe widths, the delay before ready/busy is trusted and the busy timeout are parameters counted in system clocks. The I/O bus is split into `nand_io_out`, `nand_io_oe` and `nand_io_in`, so the tri-state pad can sit at chip level.

The state machine has eleven states:

- `S_IDLE`: accepts a request and moves to `S_CMD`, or to `S_DONE` if the request is rejected.
- `S_CMD`: first command. It moves to `S_ADDR`, to `S_TWB` for `RESET` and `EXEC`, or to `S_RDATA` for `STATUS`.
- `S_ADDR`: one address byte per strobe. After the last byte it moves to `S_CONF`, `S_WFETCH`, `S_RDATA` or `S_DONE`.
- `S_WFETCH`: waits for a write byte, then moves to `S_WDATA`.
- `S_WDATA`: sends the byte. It returns to `S_WFETCH`, or moves to `S_DONE` after the last byte.
- `S_CONF`: second command, then `S_TWB`.
- `S_TWB`: fixed delay, then `S_BUSY`.
- `S_BUSY`: waits for ready, then moves to `S_RDATA`, `S_STCMD` or `S_DONE`. On timeout it moves to `S_DONE`.
- `S_STCMD`: the status command, then `S_RDATA`.
- `S_RDATA`: read strobes until the count is reached, then `S_DONE`.
- `S_DONE`: one cycle, then `S_IDLE`.

Top module: `nand_seq`

## Requirements
- R1: After reset `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale` and `nand_io_oe` are 0, and `req_ready` is 1. `req_ready` is high only in idle. `done` pulses for one cycle, and `req_ready` is high in the cycle after it.
- R2: In a command cycle `nand_cle`=1, `nand_ale`=0 and `nand_ce_n`=0, and the opcode is on `nand_io_out`. The value is taken on the rising edge of `nand_we_n`. Every low pulse of `nand_we_n` lasts exactly T_WLO clocks.
- R3: An address cycle has `nand_ale`=1 and `nand_cle`=0. A full address is five bytes in this order: column low, column high, row low, row middle, row high.
- R4: Request code 3 (READ) sends 00h, five address bytes and 30h, then waits for ready. It then reads `req_len` bytes from consecutive columns with `nand_re_n` pulses and delivers each byte on `rd_data` with `rd_valid`.
- R5: Request code 4 (LOAD) sends 80h and five address bytes. It then sends `req_len` bytes taken from the write stream, with `cle`=`ale`=0, and issues no confirm command.
- R6: Request code 5 (RANDIN) sends 85h, the two column bytes and `req_len` data bytes, and issues no confirm command. The bytes land at the new column.
- R7: Request code 6 (EXEC) sends 10h, waits for ready, sends 70h and reads one status byte. `fail` equals status bit 0.
- R8: Request code 7 (ERASE) sends 60h, the three row bytes only and D0h, waits for ready, then reads status as in R7.
- R9: Request code 0 (RESET) sends FFh and waits for ready. Until the first RESET has been issued, every other request is rejected: `done` pulses with `fail`=1 and no bus cycle occurs.
- R10: Request code 1 (READ ID) sends 90h and one address byte of 00h, then streams five bytes on `rd_data`.
- R11: Request code 2 (STATUS) sends 70h and reads one byte. The byte appears on `status`, not on the read stream, and `fail`=0.
- R12: If `nand_rb_n` stays low for BUSY_TMO clocks, the operation ends with `fail`=1 and `timeout`=1. From then until the next RESET, only RESET and STATUS are accepted; all other requests are rejected as in R9.
- R13: `nand_io_oe` is 1 only in command, address and write-data cycles. `cle` and `ale` are never both high. `nand_we_n` and `nand_re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle (idle) |
| req_op | input | 3 | Operation code (see requirements) |
| req_row | input | ROW_W | Row (page/block) address |
| req_col | input | COL_W | Column address |
| req_len | input | LEN_W | Data byte count |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Operation finished (one cycle) |
| fail | output | 1 | Operation failed or was rejected |
| timeout | output | 1 | Busy wait expired |
| status | output | 8 | Last status byte read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | I/O bus output value |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | 8 | I/O bus input value |
| nand_rb_n | input | 1 | Ready (1) / busy (0) |

## Verification
The bench builds the sequencer with T_WLO=2, T_WHI=1, T_RLO=2, T_RHI=1, T_WB=2 and BUSY_TMO=150. With the short strobes, every opcode, address ordering and page round trip runs in a few hundred cycles. With the short timeout, a device model held busy for 1000 clocks drives the abort path. That same run then exercises the gating that follows a timeout, and the recovery through RESET, all well within the run length.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    typedef enum logic [2:0] {
        OP_RESET = 3'd0,
        OP_RDID  = 3'd1,
        OP_STAT  = 3'd2,
        OP_READ  = 3'd3,
        OP_LOAD  = 3'd4,
        OP_RAND  = 3'd5,
        OP_EXEC  = 3'd6,
        OP_ERASE = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_ADDR, S_WFETCH, S_WDATA, S_CONF,
        S_TWB, S_BUSY, S_STCMD, S_RDATA, S_DONE
    } st_e;

    localparam logic [7:0] CMD_STATUS = 8'h70;

    function automatic logic [7:0] lead_cmd(op_e op);
        unique case (op)
            OP_RESET: return 8'hFF;
            OP_RDID:  return 8'h90;
            OP_STAT:  return 8'h70;
            OP_READ:  return 8'h00;
            OP_LOAD:  return 8'h80;
            OP_RAND:  return 8'h85;
            OP_EXEC:  return 8'h10;
            OP_ERASE: return 8'h60;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] confirm_cmd(op_e op);
        if (op == OP_READ)  return 8'h30;
        if (op == OP_ERASE) return 8'hD0;
        return 8'h00;
    endfunction

endpackage

// File: rtl/nseq_strobe.sv
module nseq_strobe #(
    parameter int LO = 2,
    parameter int HI = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic low,
    output logic sample,
    output logic last
);
    localparam int MX = (LO > HI) ? LO : HI;
    localparam int CW = $clog2(MX + 1);

    logic          ph;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph  <= 1'b0;
            cnt <= '0;
        end else if (!run) begin
            ph  <= 1'b0;
            cnt <= '0;
        end else if (!ph) begin
            if (cnt == CW'(LO - 1)) begin
                ph  <= 1'b1;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == CW'(HI - 1)) begin
                ph  <= 1'b0;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign low    = run && !ph;
    assign sample = run && !ph && (cnt == CW'(LO - 1));
    assign last   = run && ph && (cnt == CW'(HI - 1));
endmodule

// File: rtl/nseq_addr_mux.sv
module nseq_addr_mux #(
    parameter int COL_W = 16,
    parameter int ROW_W = 24,
    parameter int IDX_W = 3
) (
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  logic [IDX_W-1:0] idx,
    input  logic             dummy,
    output logic [7:0]       abyte
);
    localparam int NB = (COL_W + ROW_W) / 8;
    localparam int NS = 1 << IDX_W;

    logic [COL_W+ROW_W-1:0] flat;
    logic [7:0]             slot [NS];

    assign flat = {row, col};

    for (genvar gi = 0; gi < NS; gi++) begin : g_slot
        if (gi < NB) begin : g_used
            assign slot[gi] = flat[gi*8 +: 8];
        end else begin : g_pad
            assign slot[gi] = 8'h00;
        end
    end

    assign abyte = dummy ? 8'h00 : slot[idx];
endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nseq_pkg::*;
#(
    parameter int T_WLO    = 2,
    parameter int T_WHI    = 2,
    parameter int T_RLO    = 2,
    parameter int T_RHI    = 2,
    parameter int T_WB     = 4,
    parameter int BUSY_TMO = 100000,
    parameter int LEN_W    = 12,
    parameter int ID_BYTES = 5,
    parameter int COL_W    = 16,
    parameter int ROW_W    = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             fail,
    output logic             timeout,
    output logic [7:0]       status,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_in,
    input  logic             nand_rb_n
);
    localparam int COLB  = COL_W / 8;
    localparam int NAB   = (COL_W + ROW_W) / 8;
    localparam int IDX_W = $clog2(NAB);
    localparam int TW    = $clog2(BUSY_TMO + T_WB + 1);
    localparam logic [IDX_W-1:0] LAST_ALL  = IDX_W'(NAB - 1);
    localparam logic [IDX_W-1:0] LAST_COL  = IDX_W'(COLB - 1);
    localparam logic [IDX_W-1:0] FIRST_ROW = IDX_W'(COLB);

    st_e              st;
    op_e              op_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [LEN_W-1:0] len_q, bcnt, nread;
    logic [IDX_W-1:0] idx, a_last;
    logic [TW-1:0]    wcnt;
    logic [7:0]       dreg, abyte;
    logic             rd_stat, reset_seen, dev_hung;
    logic             wstate, we_low, we_last, re_low, re_smp, re_last;

    assign wstate = (st == S_CMD) || (st == S_ADDR) || (st == S_WDATA) ||
                    (st == S_CONF) || (st == S_STCMD);

    nseq_strobe #(.LO(T_WLO), .HI(T_WHI)) u_we (
        .clk(clk), .rst_n(rst_n), .run(wstate),
        .low(we_low), .sample(), .last(we_last));

    nseq_strobe #(.LO(T_RLO), .HI(T_RHI)) u_re (
        .clk(clk), .rst_n(rst_n), .run(st == S_RDATA),
        .low(re_low), .sample(re_smp), .last(re_last));

    nseq_addr_mux #(.COL_W(COL_W), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_amux (
        .col(col_q), .row(row_q), .idx(idx),
        .dummy(op_q == OP_RDID), .abyte(abyte));

    always_comb begin
        unique case (op_q)
            OP_RDID: a_last = '0;
            OP_RAND: a_last = LAST_COL;
            default: a_last = LAST_ALL;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            op_q       <= OP_RESET;
            row_q      <= '0;
            col_q      <= '0;
            len_q      <= '0;
            bcnt       <= '0;
            nread      <= '0;
            idx        <= '0;
            wcnt       <= '0;
            dreg       <= '0;
            rd_stat    <= 1'b0;
            reset_seen <= 1'b0;
            dev_hung   <= 1'b0;
            fail       <= 1'b0;
            timeout    <= 1'b0;
            status     <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (st)
                S_IDLE: if (req_valid) begin
                    op_q    <= op_e'(req_op);
                    row_q   <= req_row;
                    col_q   <= req_col;
                    len_q   <= req_len;
                    bcnt    <= '0;
                    fail    <= 1'b0;
                    timeout <= 1'b0;
                    idx     <= (op_e'(req_op) == OP_ERASE) ? FIRST_ROW : '0;
                    if (op_e'(req_op) == OP_RESET ||
                        (reset_seen && (!dev_hung || op_e'(req_op) == OP_STAT)))
                        st <= S_CMD;
                    else begin
                        fail <= 1'b1;
                        st   <= S_DONE;
                    end
                end
                S_CMD: if (we_last) begin
                    unique case (op_q)
                        OP_RESET: begin
                            reset_seen <= 1'b1;
                            dev_hung   <= 1'b0;
                            wcnt       <= '0;
                            st         <= S_TWB;
                        end
                        OP_EXEC: begin
                            wcnt <= '0;
                            st   <= S_TWB;
                        end
                        OP_STAT: begin
                            nread   <= LEN_W'(1);
                            rd_stat <= 1'b1;
                            st      <= S_RDATA;
                        end
                        default: st <= S_ADDR;
                    endcase
                end
                S_ADDR: if (we_last) begin
                    if (idx != a_last) idx <= idx + 1'b1;
                    else begin
                        unique case (op_q)
                            OP_READ, OP_ERASE: st <= S_CONF;
                            OP_RDID: begin
                                nread   <= LEN_W'(ID_BYTES);
                                rd_stat <= 1'b0;
                                st      <= S_RDATA;
                            end
                            default: st <= (len_q == '0) ? S_DONE : S_WFETCH;
                        endcase
                    end
                end
                S_WFETCH: if (wr_valid) begin
                    dreg <= wr_data;
                    st   <= S_WDATA;
                end
                S_WDATA: if (we_last) begin
                    bcnt <= bcnt + 1'b1;
                    st   <= (LEN_W'(bcnt + 1'b1) == len_q) ? S_DONE : S_WFETCH;
                end
                S_CONF: if (we_last) begin
                    wcnt <= '0;
                    st   <= S_TWB;
                end
                S_TWB: begin
                    if (wcnt == TW'(T_WB - 1)) begin
                        wcnt <= '0;
                        st   <= S_BUSY;
                    end else wcnt <= wcnt + 1'b1;
                end
                S_BUSY: begin
                    if (nand_rb_n) begin
                        bcnt <= '0;
                        unique case (op_q)
                            OP_READ: begin
                                nread   <= len_q;
                                rd_stat <= 1'b0;
                                st      <= (len_q == '0) ? S_DONE : S_RDATA;
                            end
                            OP_EXEC, OP_ERASE: st <= S_STCMD;
                            default: st <= S_DONE;
                        endcase
                    end else if (wcnt == TW'(BUSY_TMO - 1)) begin
                        fail     <= 1'b1;
                        timeout  <= 1'b1;
                        dev_hung <= 1'b1;
                        st       <= S_DONE;
                    end else wcnt <= wcnt + 1'b1;
                end
                S_STCMD: if (we_last) begin
                    bcnt    <= '0;
                    nread   <= LEN_W'(1);
                    rd_stat <= 1'b1;
                    st      <= S_RDATA;
                end
                S_RDATA: begin
                    if (re_smp) begin
                        if (rd_stat) begin
                            status <= nand_io_in;
                            if (op_q == OP_EXEC || op_q == OP_ERASE)
                                fail <= nand_io_in[0];
                        end else begin
                            rd_data  <= nand_io_in;
                            rd_valid <= 1'b1;
                        end
                    end
                    if (re_last) begin
                        bcnt <= bcnt + 1'b1;
                        if (LEN_W'(bcnt + 1'b1) == nread) st <= S_DONE;
                    end
                end
                S_DONE: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready   = (st == S_IDLE);
        wr_ready    = (st == S_WFETCH);
        done        = (st == S_DONE);
        nand_ce_n   = (st == S_IDLE) || (st == S_DONE);
        nand_cle    = (st == S_CMD) || (st == S_CONF) || (st == S_STCMD);
        nand_ale    = (st == S_ADDR);
        nand_we_n   = !we_low;
        nand_re_n   = !re_low;
        nand_io_oe  = wstate;
        unique case (st)
            S_CMD:   nand_io_out = lead_cmd(op_q);
            S_ADDR:  nand_io_out = abyte;
            S_WDATA: nand_io_out = dreg;
            S_CONF:  nand_io_out = confirm_cmd(op_q);
            S_STCMD: nand_io_out = CMD_STATUS;
            default: nand_io_out = 8'h00;
        endcase
    end

    // R13
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R13
    oe_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_io_oe |-> nand_re_n);
    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    // R9
    reset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_seen && nand_cle) |-> (nand_io_out == 8'hFF));
    // R1
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);
endmodule

// File: tb/nand_seq_test.sv
module nand_seq_test;
    localparam int T_WLO = 2;
    localparam int T_WHI = 1;
    localparam int TMO   = 150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [23:0] req_row = '0;
    logic [15:0] req_col = '0;
    logic [11:0] req_len = '0;
    logic        wr_valid = 1'b1;
    logic        wr_ready;
    logic [7:0]  wr_data;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        done, fail, timeout;
    logic [7:0]  status;
    logic        ce_n, cle, ale, we_n, re_n, io_oe;
    logic [7:0]  io_out, io_in;
    logic        rb_n;

    always #5 clk = ~clk;

    nand_seq #(.T_WLO(T_WLO), .T_WHI(T_WHI), .T_RLO(2), .T_RHI(1), .T_WB(2),
               .BUSY_TMO(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .fail(fail),
        .timeout(timeout), .status(status), .nand_ce_n(ce_n), .nand_cle(cle),
        .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n), .nand_io_out(io_out),
        .nand_io_oe(io_oe), .nand_io_in(io_in), .nand_rb_n(rb_n));

    integer nchk = 0, nfail = 0;

    // ---------------- behavioural device model ----------------
    logic [7:0] mem [256];
    logic [7:0] pbuf [256];
    integer ptr = 0, acnt = 0, mode = 0, cyc = 0, busy_until = 0, busy_len = 20;
    bit     dev_fail_bit = 0;
    logic [7:0] dev_out = 8'h00;
    logic [9:0] evq [$];
    logic [7:0] rdq [$];
    logic [9:0] expq [$];

    function automatic logic [7:0] id_byte(int i);
        case (i)
            0: return 8'h3C;
            1: return 8'h71;
            2: return 8'h0E;
            3: return 8'hB2;
            default: return 8'h58;
        endcase
    endfunction

    assign rb_n  = (cyc >= busy_until);
    assign io_in = dev_out;

    initial for (int i = 0; i < 256; i++) begin mem[i] = 8'hFF; pbuf[i] = 8'hFF; end

    always @(negedge clk) cyc = cyc + 1;

    always @(posedge we_n) if (ce_n === 1'b0) begin
        evq.push_back({cle, ale, io_out});
        if (cle) begin
            acnt = 0;
            case (io_out)
                8'h80: begin for (int i = 0; i < 256; i++) pbuf[i] = 8'hFF; mode = 0; end
                8'h00: mode = 0;
                8'h70: mode = 2;
                8'h90: begin mode = 1; ptr = 0; end
                8'h30: busy_until = cyc + busy_len;
                8'h10: begin
                    for (int i = 0; i < 256; i++) mem[i] = pbuf[i];
                    busy_until = cyc + busy_len;
                end
                8'hD0: begin
                    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
                    busy_until = cyc + busy_len;
                end
                8'hFF: begin mode = 0; busy_until = cyc + 5; end
                default: ;
            endcase
        end else if (ale) begin
            if (acnt == 0) ptr = io_out;
            acnt = acnt + 1;
        end else begin
            pbuf[ptr[7:0]] = io_out;
            ptr = ptr + 1;
        end
    end

    always @(negedge re_n) if (ce_n === 1'b0) begin
        if (mode == 2)      dev_out = {1'b1, rb_n, 5'b0, dev_fail_bit};
        else if (mode == 1) dev_out = id_byte(ptr);
        else                dev_out = mem[ptr[7:0]];
    end
    always @(posedge re_n) if (ce_n === 1'b0 && mode != 2) ptr = ptr + 1;

    // ---------------- per-clock monitors ----------------
    logic [7:0] wdq [$];
    integer wr_idx = 0;
    bit     took = 0;
    integer inv_bad = 0, we_bad = 0, we_lo = 0;
    assign wr_data = (wr_idx < wdq.size()) ? wdq[wr_idx] : 8'h00;

    always @(negedge clk) if (rst_n) begin
        if (took) wr_idx = wr_idx + 1;
        took = wr_ready && wr_valid;
        if (rd_valid) rdq.push_back(rd_data);
        if ((cle && ale) || (!we_n && !re_n) || (io_oe && !re_n) ||
            (io_oe && !cle && !ale && !we_n && ce_n)) inv_bad++;
        if (!we_n) we_lo++;
        else begin
            if (we_lo != 0 && we_lo != T_WLO) we_bad++;
            we_lo = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ex(input bit c, input bit a, input logic [7:0] b);
        expq.push_back({c, a, b});
    endtask

    task automatic check_events(input string tag);
        bit ok = (evq.size() == expq.size());
        int bad = -1;
        if (ok) for (int i = 0; i < evq.size(); i++)
            if (evq[i] != expq[i]) begin ok = 0; bad = i; break; end
        if (bad >= 0) check(0, tag, evq[bad], expq[bad]);
        else check(ok, tag, evq.size(), expq.size());
        expq.delete();
    endtask

    logic r_fail, r_tmo;
    logic [7:0] r_stat;

    task automatic do_op(input logic [2:0] op, input logic [23:0] row,
                         input logic [15:0] col, input logic [11:0] len);
        int n = 0;
        evq.delete(); rdq.delete();
        @(negedge clk);
        req_op = op; req_row = row; req_col = col; req_len = len; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        if (n >= 5000) check(0, "watchdog", n, 0);
        r_fail = fail; r_tmo = timeout; r_stat = status;
        @(negedge clk);
    endtask

    task automatic load_wr(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3, input int n);
        wdq.delete(); wr_idx = 0;
        if (n > 0) wdq.push_back(b0);
        if (n > 1) wdq.push_back(b1);
        if (n > 2) wdq.push_back(b2);
        if (n > 3) wdq.push_back(b3);
    endtask

    task automatic check_rd(input string tag, input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3, input int n);
        logic [7:0] e [4];
        bit ok = (rdq.size() == n);
        e[0] = b0; e[1] = b1; e[2] = b2; e[3] = b3;
        if (ok) for (int i = 0; i < n; i++) if (rdq[i] != e[i]) ok = 0;
        check(ok, tag, (rdq.size() > 0) ? rdq[0] : 0, b0);
    endtask

    // ---------------- watchdog ----------------
    bit finished = 0;
    initial begin
        #1_500_000;
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({ce_n, we_n, re_n, cle, ale, io_oe, req_ready} == 7'b1110001, "R1 reset state",
              {ce_n, we_n, re_n, cle, ale, io_oe, req_ready}, 7'b1110001);

        // R9 reject before first reset
        do_op(3'd3, 24'h1, 16'h0, 12'd2);
        check(r_fail && evq.size() == 0, "R9 reject before reset", evq.size(), 0);

        // R9 reset
        do_op(3'd0, 24'h0, 16'h0, 12'd0);
        ex(1, 0, 8'hFF);
        check_events("R9 reset sequence");
        check(!r_fail, "R9 reset result", r_fail, 0);

        // R10 read id
        do_op(3'd1, 24'h0, 16'h0, 12'd0);
        ex(1, 0, 8'h90); ex(0, 1, 8'h00);
        check_events("R10 read id cycles");
        check(rdq.size() == 5 && rdq[0] == 8'h3C && rdq[4] == 8'h58, "R10 id bytes",
              rdq.size(), 5);

        // R11 status
        do_op(3'd2, 24'h0, 16'h0, 12'd0);
        ex(1, 0, 8'h70);
        check_events("R11 status cycles");
        check(r_stat == 8'hC0 && rdq.size() == 0 && !r_fail, "R11 status byte", r_stat, 8'hC0);

        // R5 / R3 load
        load_wr(8'hA0, 8'hA1, 8'hA2, 8'hA3, 4);
        do_op(3'd4, 24'h123456, 16'h0010, 12'd4);
        ex(1, 0, 8'h80); ex(0, 1, 8'h10); ex(0, 1, 8'h00);
        ex(0, 1, 8'h56); ex(0, 1, 8'h34); ex(0, 1, 8'h12);
        ex(0, 0, 8'hA0); ex(0, 0, 8'hA1); ex(0, 0, 8'hA2); ex(0, 0, 8'hA3);
        check_events("R5 R3 load cycles");

        // R6 random data input
        load_wr(8'hB0, 8'hB1, 8'h00, 8'h00, 2);
        do_op(3'd5, 24'h123456, 16'h0040, 12'd2);
        ex(1, 0, 8'h85); ex(0, 1, 8'h40); ex(0, 1, 8'h00);
        ex(0, 0, 8'hB0); ex(0, 0, 8'hB1);
        check_events("R6 random input cycles");

        // R7 exec pass
        do_op(3'd6, 24'h0, 16'h0, 12'd0);
        ex(1, 0, 8'h10); ex(1, 0, 8'h70);
        check_events("R7 exec cycles");
        check(!r_fail && r_stat[0] == 1'b0, "R7 exec pass", r_fail, 0);

        // R4 read back
        do_op(3'd3, 24'h123456, 16'h0010, 12'd4);
        ex(1, 0, 8'h00); ex(0, 1, 8'h10); ex(0, 1, 8'h00);
        ex(0, 1, 8'h56); ex(0, 1, 8'h34); ex(0, 1, 8'h12); ex(1, 0, 8'h30);
        check_events("R4 read cycles");
        check_rd("R4 read data", 8'hA0, 8'hA1, 8'hA2, 8'hA3, 4);
        do_op(3'd3, 24'h123456, 16'h0040, 12'd2);
        check_rd("R6 random bytes placed", 8'hB0, 8'hB1, 8'h00, 8'h00, 2);

        // R7 exec fail
        dev_fail_bit = 1;
        do_op(3'd6, 24'h0, 16'h0, 12'd0);
        check(r_fail && r_stat[0], "R7 exec fail flag", r_fail, 1);
        dev_fail_bit = 0;

        // R8 erase
        do_op(3'd7, 24'h0A0B0C, 16'h1234, 12'd0);
        ex(1, 0, 8'h60); ex(0, 1, 8'h0C); ex(0, 1, 8'h0B); ex(0, 1, 8'h0A);
        ex(1, 0, 8'hD0); ex(1, 0, 8'h70);
        check_events("R8 erase cycles");
        check(!r_fail, "R8 erase pass", r_fail, 0);
        do_op(3'd3, 24'h123456, 16'h0010, 12'd2);
        check_rd("R8 erased data", 8'hFF, 8'hFF, 8'h00, 8'h00, 2);

        // R12 timeout
        busy_len = 1000;
        do_op(3'd6, 24'h0, 16'h0, 12'd0);
        check(r_fail && r_tmo, "R12 timeout flags", {r_fail, r_tmo}, 3);
        ex(1, 0, 8'h10);
        check_events("R12 no status after timeout");
        do_op(3'd3, 24'h0, 16'h0010, 12'd2);
        check(r_fail && evq.size() == 0, "R12 read rejected while hung", evq.size(), 0);
        do_op(3'd2, 24'h0, 16'h0, 12'd0);
        check(!r_fail && evq.size() == 1 && r_stat[6] == 1'b0, "R12 status allowed while hung",
              r_stat, 8'h80);
        busy_len = 20;
        do_op(3'd0, 24'h0, 16'h0, 12'd0);
        check(!r_fail, "R12 reset recovers", r_fail, 0);
        do_op(3'd3, 24'h0, 16'h0010, 12'd2);
        check(!r_fail && rdq.size() == 2, "R12 read after recovery", rdq.size(), 2);

        // R2 / R13 monitors
        check(we_bad == 0, "R2 write strobe width", we_bad, 0);
        check(inv_bad == 0, "R13 bus invariants", inv_bad, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule